// File: doc/BRIEF.md
# Freezable Serial Peripheral Master

This block is a single-channel serial peripheral master that moves fixed-length frames. It drives the serial clock, an active-low chip select and the outgoing data line, and samples the incoming data line. The host starts a frame with a one-cycle `start` pulse that carries the outgoing byte. A one-cycle `done` pulse marks the end of each frame and presents the received byte on `rx_data`.

Two host control bits change how the engine runs. `ctl_disable` stops the half-period tick generator, and with it every state change in the shift engine. The stored byte and any pending request are kept, so the engine picks up where it stopped once the bit clears. `ctl_freeze_en` makes the engine obey the external `dbg_req` input. A request that arrives during a frame lets that frame finish. After that the engine parks in a halted state and starts nothing new until the request drops. When `ctl_freeze_en` is low, `dbg_req` has no effect.

The controller has five states: IDLE, LEAD, SHIFT, TRAIL and HALT. Every transition is taken only on a half-period tick:
- IDLE to LEAD launches a pending frame when no freeze is asked for.
- IDLE to HALT is taken when a freeze is asked for.
- HALT to IDLE is taken once the request is gone.
- LEAD to SHIFT is the first rising clock edge.
- SHIFT to TRAIL is taken after the last falling edge.
- TRAIL to IDLE raises chip select and pulses `done`.

Top module: `spi_frz_master`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `done`=0, `busy`=0 and `halted`=0.
- R2: Each frame has exactly 8 rising `sclk` edges with the clock idle low. `mosi` presents `tx_data` MSB first and is stable at each rising edge. `miso` is sampled on each rising edge into `rx_data`, with the first sampled bit becoming bit 7.
- R3: `cs_n` falls HALF_DIV clock cycles before the first rising `sclk` edge. It rises HALF_DIV clock cycles after the last falling edge. `sclk` is low whenever `cs_n` is high.
- R4: `done` is high for exactly one cycle per frame. That cycle is the first one with `cs_n` high again, and `rx_data` already holds the received byte in it.
- R5: A `start` pulse while `busy`=1 is ignored. It neither alters the frame in flight nor causes an extra frame.
- R6: When `ctl_freeze_en`=1 and `dbg_req`=1, a frame in progress completes normally and `halted` then goes to 1. No new frame starts while the request stays high, even with a start pending. After `dbg_req` falls, the pending frame runs.
- R7: When `ctl_freeze_en`=0, `dbg_req`=1 has no effect: frames run normally and `halted` stays 0.
- R8: While `ctl_disable`=1, `sclk`, `cs_n` and `mosi` hold their values and no `done` occurs. After the bit clears, the interrupted frame finishes with the correct data.
- R9: A start accepted while `ctl_disable`=1 does not begin until the bit clears. `cs_n` then falls within HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_disable | input | 1 | Host bit: stop the shift engine |
| ctl_freeze_en | input | 1 | Host bit: honour the debug request |
| dbg_req | input | 1 | External debug request |
| start | input | 1 | One-cycle frame request |
| tx_data | input | 8 | Byte to send, taken with `start` |
| rx_data | output | 8 | Last received byte |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame pending or in flight |
| halted | output | 1 | Engine parked by freeze |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The two functions that can fall in the same cycle are the end of a frame and the arrival of a freeze request. The coincidence is provoked by raising `dbg_req` and pulsing a new `start` in the very cycle `done` is high. The test then checks three things:
- the finished frame carries correct data;
- the engine goes to HALT rather than launching the new request;
- the request still runs, with its own byte, once `dbg_req` falls.

A second overlap is a start pending while disabled. Clearing the disable bit must launch that start within one tick.

// File: rtl/spi_frz_pkg.sv
package spi_frz_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_HALT
    } spi_state_t;
endpackage

// File: rtl/spi_frz_tick.sv
module spi_frz_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_frz_shifter.sv
module spi_frz_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            rise,
    input  logic            shift,
    input  logic            capture,
    input  logic            miso,
    output logic            mosi,
    output logic [BITS-1:0] rx_data
);
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] rx_sh;

    assign mosi = tx_sh[BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_data <= '0;
        end else begin
            if (load) begin
                tx_sh <= load_data;
            end else if (shift) begin
                tx_sh <= {tx_sh[BITS-2:0], 1'b0};
            end
            if (rise) begin
                rx_sh <= {rx_sh[BITS-2:0], miso};
            end
            if (capture) begin
                rx_data <= rx_sh;
            end
        end
    end
endmodule

// File: rtl/spi_frz_fsm.sv
module spi_frz_fsm
    import spi_frz_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic freeze_en,
    input  logic dbg_req,
    output logic accept,
    output logic rise,
    output logic shift,
    output logic capture,
    output logic sclk,
    output logic cs_n,
    output logic done,
    output logic busy,
    output logic halted
);
    localparam int BW = $clog2(BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(BITS - 1);

    spi_state_t state, state_nx;
    logic          pend;
    logic [BW-1:0] bitcnt;
    logic          hold;
    logic          launch;
    logic          fall_edge;
    logic          last;

    assign hold      = freeze_en && dbg_req;
    assign last      = (bitcnt == LAST_BIT);
    assign launch    = tick && (state == ST_IDLE) && pend && !hold;
    assign rise      = tick && ((state == ST_LEAD) || ((state == ST_SHIFT) && !sclk));
    assign fall_edge = tick && (state == ST_SHIFT) && sclk;
    assign shift     = fall_edge && !last;
    assign capture   = tick && (state == ST_TRAIL);
    assign busy      = pend || (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL);
    assign accept    = start && !busy;
    assign halted    = (state == ST_HALT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tick && hold) state_nx = ST_HALT;
                      else if (launch) state_nx = ST_LEAD;
            ST_HALT:  if (tick && !hold) state_nx = ST_IDLE;
            ST_LEAD:  if (tick) state_nx = ST_SHIFT;
            ST_SHIFT: if (fall_edge && last) state_nx = ST_TRAIL;
            ST_TRAIL: if (tick) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            bitcnt <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (accept) begin
                pend <= 1'b1;
            end else if (launch) begin
                pend <= 1'b0;
            end
            if (launch) begin
                bitcnt <= '0;
            end else if (shift) begin
                bitcnt <= bitcnt + 1'b1;
            end
            if (rise) begin
                sclk <= 1'b1;
            end else if (fall_edge) begin
                sclk <= 1'b0;
            end
            if (launch) begin
                cs_n <= 1'b0;
            end else if (capture) begin
                cs_n <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_frz_master.sv
module spi_frz_master #(
    parameter int BITS     = 8,
    parameter int HALF_DIV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_disable,
    input  logic            ctl_freeze_en,
    input  logic            dbg_req,
    input  logic            start,
    input  logic [BITS-1:0] tx_data,
    output logic [BITS-1:0] rx_data,
    output logic            done,
    output logic            busy,
    output logic            halted,
    output logic            sclk,
    output logic            cs_n,
    output logic            mosi,
    input  logic            miso
);
    logic tick, accept, rise, shift, capture;

    spi_frz_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!ctl_disable),
        .tick  (tick)
    );

    spi_frz_fsm #(.BITS(BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (start),
        .freeze_en (ctl_freeze_en),
        .dbg_req   (dbg_req),
        .accept    (accept),
        .rise      (rise),
        .shift     (shift),
        .capture   (capture),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .done      (done),
        .busy      (busy),
        .halted    (halted)
    );

    spi_frz_shifter #(.BITS(BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (tx_data),
        .rise      (rise),
        .shift     (shift),
        .capture   (capture),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );
endmodule

// File: rtl/spi_frz_checker.sv
module spi_frz_checker (
    input logic clk,
    input logic rst_n,
    input logic ctl_disable,
    input logic ctl_freeze_en,
    input logic dbg_req,
    input logic done,
    input logic halted,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);
    a_r3_clock_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_with_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    a_r8_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_disable |=> ($stable(sclk) && $stable(cs_n) && $stable(mosi) && !done));

    a_r6_no_launch_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_freeze_en && dbg_req && cs_n) |=> cs_n);

    a_r7_halt_needs_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(ctl_freeze_en && dbg_req));

    a_r6_halted_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> cs_n);
endmodule

bind spi_frz_master spi_frz_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_disable   (ctl_disable),
    .ctl_freeze_en (ctl_freeze_en),
    .dbg_req       (dbg_req),
    .done          (done),
    .halted        (halted),
    .sclk          (sclk),
    .cs_n          (cs_n),
    .mosi          (mosi)
);

// File: tb/sim_spi_frz_master.sv
module sim_spi_frz_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_disable = 1'b0;
    logic       ctl_freeze_en = 1'b0;
    logic       dbg_req = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic       done, busy, halted, sclk, cs_n, mosi;
    logic       miso = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int frames = 0;

    logic [7:0] exp_tx = 8'h00;
    logic [7:0] exp_rx = 8'h00;

    spi_frz_master #(.BITS(8), .HALF_DIV(HALF_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_disable(ctl_disable),
        .ctl_freeze_en(ctl_freeze_en), .dbg_req(dbg_req), .start(start),
        .tx_data(tx_data), .rx_data(rx_data), .done(done), .busy(busy),
        .halted(halted), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // slave model and frame monitor, sampled on the falling system clock edge
    logic       p_sclk = 1'b0, p_cs = 1'b1;
    int         t_csfall = 0, t_lastfall = 0, nrise = 0, idx = 0;
    logic [7:0] cap = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !cs_n) begin
                t_csfall = cyc; nrise = 0; cap = 8'h00;
                miso <= exp_rx[7]; idx = 6;
            end
            if (!p_sclk && sclk) begin
                if (nrise == 0)
                    check(cyc - t_csfall == HALF_DIV, "R3 lead", cyc - t_csfall, HALF_DIV);
                cap = {cap[6:0], mosi};
                nrise++;
            end
            if (p_sclk && !sclk) begin
                t_lastfall = cyc;
                if (idx >= 0) begin miso <= exp_rx[idx]; idx--; end
            end
            if (cs_n && sclk) check(1'b0, "R3 sclk high while deselected", 1, 0);
            if (!p_cs && cs_n) begin
                check(cyc - t_lastfall == HALF_DIV, "R3 trail", cyc - t_lastfall, HALF_DIV);
                check(nrise == 8, "R2 edge count", nrise, 8);
                check(cap == exp_tx, "R2 mosi byte", cap, exp_tx);
                check(done == 1'b1, "R4 done at deselect", done, 1);
                check(rx_data == exp_rx, "R2 rx byte", rx_data, exp_rx);
                frames++;
            end else if (done) begin
                check(1'b0, "R4 stray done", 1, 0);
            end
            p_sclk = sclk;
            p_cs = cs_n;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [7:0] d);
        tx_data = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_frames(input int target, input string req);
        int t = 0;
        while (frames < target && t < 2000) begin
            @(negedge clk); t++;
        end
        check(frames >= target, req, frames, target);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [7:0] r, input string req);
        int f0 = frames;
        exp_tx = d; exp_rx = r;
        pulse_start(d);
        wait_frames(f0 + 1, req);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        logic s_sclk, s_cs, s_mosi;
        wait_cycles(3);
        check(cs_n == 1 && sclk == 0 && done == 0 && busy == 0 && halted == 0,
              "R1 reset state", {cs_n, sclk, done, busy, halted}, 5'b10000);
        rst_n = 1'b1;
        wait_cycles(3);

        // R2 R3 R4: exhaustive sweep of outgoing bytes
        for (int i = 0; i < 256; i++)
            run_frame(8'(i), 8'((i * 37 + 11) & 255), "R2 sweep frame");

        // R5: start while busy ignored
        f0 = frames;
        exp_tx = 8'hC3; exp_rx = 8'h96;
        pulse_start(8'hC3);
        wait_cycles(10);
        check(busy == 1'b1, "R5 busy in flight", busy, 1);
        pulse_start(8'h3C);
        wait_frames(f0 + 1, "R5 first frame");
        wait_cycles(60);
        check(frames == f0 + 1 && cs_n && !busy, "R5 no extra frame", frames - f0, 1);

        // R7: freeze disabled, request has no effect
        ctl_freeze_en = 1'b0; dbg_req = 1'b1;
        run_frame(8'h5A, 8'hA5, "R7 frame with request");
        check(halted == 1'b0, "R7 not halted", halted, 0);
        wait_cycles(10);
        check(halted == 1'b0, "R7 still not halted", halted, 0);
        dbg_req = 1'b0;

        // R6: request mid-frame with freeze enabled
        ctl_freeze_en = 1'b1;
        f0 = frames;
        exp_tx = 8'h81; exp_rx = 8'h7E;
        pulse_start(8'h81);
        wait_cycles(10);
        dbg_req = 1'b1;
        wait_frames(f0 + 1, "R6 frame completes");
        wait_cycles(2 * HALF_DIV + 2);
        check(halted == 1'b1, "R6 halted", halted, 1);
        exp_tx = 8'h24; exp_rx = 8'hDB;
        pulse_start(8'h24);
        wait_cycles(60);
        check(frames == f0 + 1 && cs_n && busy, "R6 no launch while frozen", frames - f0, 1);
        dbg_req = 1'b0;
        wait_frames(f0 + 2, "R6 resumed frame");
        check(halted == 1'b0, "R6 released", halted, 0);

        // R6 coincidence: request and new start in the done cycle
        f0 = frames;
        exp_tx = 8'hF0; exp_rx = 8'h0F;
        pulse_start(8'hF0);
        while (!done) @(negedge clk);
        dbg_req = 1'b1;
        tx_data = 8'h99; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_tx = 8'h99; exp_rx = 8'h66;
        wait_cycles(2 * HALF_DIV + 2);
        check(halted == 1'b1 && cs_n, "R6 halt after coincident done", halted, 1);
        wait_cycles(40);
        check(frames == f0 + 1, "R6 coincident start held", frames - f0, 1);
        dbg_req = 1'b0;
        wait_frames(f0 + 2, "R6 coincident start runs");
        ctl_freeze_en = 1'b0;

        // R8: disable mid-frame
        f0 = frames;
        exp_tx = 8'hB2; exp_rx = 8'h4D;
        pulse_start(8'hB2);
        wait_cycles(12);
        ctl_disable = 1'b1;
        @(negedge clk);
        s_sclk = sclk; s_cs = cs_n; s_mosi = mosi;
        wait_cycles(50);
        check(sclk == s_sclk && cs_n == s_cs && mosi == s_mosi && frames == f0,
              "R8 frozen by disable", {sclk, cs_n, mosi}, {s_sclk, s_cs, s_mosi});
        check(cs_n == 1'b0, "R8 stopped mid-frame", cs_n, 0);
        ctl_disable = 1'b0;
        wait_frames(f0 + 1, "R8 frame finishes");

        // R9: start pending while disabled
        wait_cycles(10);
        f0 = frames;
        ctl_disable = 1'b1;
        exp_tx = 8'h6E; exp_rx = 8'h1D;
        pulse_start(8'h6E);
        wait_cycles(30);
        check(cs_n == 1'b1 && frames == f0, "R9 held while disabled", cs_n, 1);
        ctl_disable = 1'b0;
        wait_cycles(HALF_DIV);
        check(cs_n == 1'b0, "R9 launch after enable", cs_n, 0);
        wait_frames(f0 + 1, "R9 frame done");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule